// File: doc/BRIEF.md
# Pipelined no-turnaround burst SRAM

A single-clock synchronous memory whose address, control and write data all pass through registers on the rising clock edge. Read, write and deselect commands can follow one another on every edge with no idle cycle at a read-to-write or write-to-read switch. This works because both directions use the data bus exactly two enabled edges after their command. Read data leaves the output register after the second enabled edge. Write data, with its byte enables, is sampled at the second enabled edge. A read that targets the address of the write just ahead of it receives the in-flight bytes.

A command either loads an external address or advances a 2-bit burst counter inside the block. The counter walks the low two address bits in linear or interleaved order, depending on a static mode input. A clock enable freezes the whole pipeline. A sleep input, after a two-edge entry delay, ignores every other input and keeps all state. An output enable gates the read result asynchronously. That result is presented as a data word with a valid flag instead of a tristate bus.

Top module: `pipe_burst_sram`

## Requirements
- R1: An enabled edge (cke_n low, not asleep) with adv low and at least one bit of cs_n low starts a new command at `addr`. It is a read when we_n is high and a write when we_n is low.
- R2: Read data for a command appears on rdata with rvalid high after the second enabled edge that follows the command. rvalid additionally needs oe_n low, and oe_n acts combinationally: raising it drops rvalid at once and lowering it brings rvalid back.
- R3: The write data for a write command is sampled at the second enabled edge after the command. Reads and writes may alternate on consecutive edges with no idle cycle.
- R4: adv high on an enabled edge issues the next beat of the current burst, of the same type (read, write or deselect), whatever we_n and cs_n are. Upper address bits stay fixed. The low two bits are the start bits plus the beat number modulo 4 when burst_ilv is 0, and the start bits XOR the beat number when burst_ilv is 1. The fifth beat wraps back to the start address.
- R5: With cke_n high every other synchronous input is ignored and all pipeline and output registers keep their values. Only enabled edges count toward the latency in R2 and R3.
- R6: be_n is sampled together with the write data. be_n[i] low writes bits [9i+8:9i]. be_n = 4'b1111 turns the write into a no-op that leaves the array unchanged.
- R7: cs_n = 2'b11 with adv low is a deselect: no data returns for it. adv high after a deselect continues the deselect, and no read or write takes place.
- R8: When sleep has been high at an edge, the edges from the second one after it onward ignore every other input, and rvalid is held low. Normal operation returns on the second edge after sleep is sampled low. Array contents and the pipeline state, including a pending read result, are preserved.
- R9: A read issued on the edge directly after a write to the same address returns the write's data, merged lane by lane with the old contents under that write's byte enables.
- R10: Synchronous active-high rst empties the pipeline, drops rvalid, clears the sleep delay and leaves the burst state as deselected, so an adv-high cycle right after reset performs no access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_n | input | 1 | Clock enable, active low; high stalls the block |
| cs_n | input | 2 | Two active-low selects; both high means deselect |
| adv | input | 1 | 0 = load a new command, 1 = advance the current burst |
| we_n | input | 1 | Command type on a load: 1 read, 0 write |
| addr | input | AW (10) | Word address for a load |
| be_n | input | 4 | Active-low byte lane enables, sampled with the write data |
| wdata | input | 36 | Write data, two enabled edges after its command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Sleep request, active high |
| rdata | output | 36 | Read data, zero when rvalid is low |
| rvalid | output | 1 | Read data is valid and enabled |

## Verification
A wrong beat from the burst counter shows as a wrong data word exactly two enabled edges after that beat is issued. Burst read-back in both orders, including the wrapping fifth beat, is therefore compared word by word. A pipeline slot that is lost or shifted during a stall or a sleep period shows up as rvalid arriving at the wrong edge, or as a held result that changes. The bench checks rvalid on the stalled and sleeping edges themselves, not only afterwards. A missing bypass shows up as stale bytes on the read issued right after a write, visible two edges after that read, with partial byte enables so that individual lanes can be told apart.

// File: rtl/nbs_pkg.sv
`timescale 1ns/1ps
package nbs_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low two address bits of a burst beat: add (linear) or XOR (interleaved).
    function automatic logic [1:0] beat_low(input logic [1:0] start,
                                            input logic [1:0] beat,
                                            input logic       interleave);
        logic [1:0] r;
        if (interleave) r = start ^ beat;
        else            r = start + beat;
        return r;
    endfunction

endpackage

// File: rtl/nbs_sleep_gate.sv
`timescale 1ns/1ps
module nbs_sleep_gate #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_i,
    output logic asleep_o
);
    logic [DLY-1:0] sq;

    generate
        if (DLY == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sq <= '0;
                else     sq <= sleep_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sq <= '0;
                else     sq <= {sq[DLY-2:0], sleep_i};
            end
        end
    endgenerate

    assign asleep_o = sq[DLY-1];
endmodule

// File: rtl/nbs_burst_gen.sv
`timescale 1ns/1ps
module nbs_burst_gen
    import nbs_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          adv,
    input  logic [1:0]    cs_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic          interleave,
    output op_e           cmd_op,
    output logic [AW-1:0] cmd_addr
);
    op_e           op_q;
    logic [AW-1:0] base_q;
    logic [1:0]    beat_q;
    logic [1:0]    beat_nx;
    op_e           load_op;

    assign beat_nx = beat_q + 2'd1;

    always_comb begin
        if (cs_n == 2'b11) load_op = OP_IDLE;
        else if (we_n)     load_op = OP_READ;
        else               load_op = OP_WRITE;
    end

    always_comb begin
        if (!adv) begin
            cmd_op   = load_op;
            cmd_addr = addr;
        end else begin
            cmd_op   = op_q;
            cmd_addr = {base_q[AW-1:2], beat_low(base_q[1:0], beat_nx, interleave)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_IDLE;
            base_q <= '0;
            beat_q <= 2'd0;
        end else if (go) begin
            if (!adv) begin
                op_q   <= load_op;
                base_q <= addr;
                beat_q <= 2'd0;
            end else begin
                beat_q <= beat_nx;
            end
        end
    end
endmodule

// File: rtl/nbs_array.sv
`timescale 1ns/1ps
module nbs_array #(
    parameter int AW     = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [LANES-1:0]        wr_be_n,
    input  logic [LANE_W*LANES-1:0] wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [LANE_W*LANES-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [LANE_W-1:0] mem [DEPTH];

            always_ff @(posedge clk) begin
                if (wr_en && !wr_be_n[l])
                    mem[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
            end

            assign rd_data[l*LANE_W +: LANE_W] = mem[rd_addr];
        end
    endgenerate
endmodule

// File: rtl/pipe_burst_sram.sv
`timescale 1ns/1ps
module pipe_burst_sram
    import nbs_pkg::*;
#(
    parameter int AW       = 10,
    parameter int LANE_W   = 9,
    parameter int LANES    = 4,
    parameter int WAKE_DLY = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cke_n,
    input  logic [1:0]              cs_n,
    input  logic                    adv,
    input  logic                    we_n,
    input  logic [AW-1:0]           addr,
    input  logic [LANES-1:0]        be_n,
    input  logic [LANE_W*LANES-1:0] wdata,
    input  logic                    oe_n,
    input  logic                    burst_ilv,
    input  logic                    sleep,
    output logic [LANE_W*LANES-1:0] rdata,
    output logic                    rvalid
);
    localparam int DW = LANE_W * LANES;

    typedef struct packed {
        op_e           op;
        logic [AW-1:0] addr;
    } slot_t;

    logic          asleep;
    logic          go;
    op_e           cmd_op;
    logic [AW-1:0] cmd_addr;
    slot_t         cmd_slot;
    slot_t         s1_q;
    slot_t         s2_q;
    op_e           s1_op;
    logic          wr_commit;
    logic          same_addr;
    logic [DW-1:0] arr_rd;
    logic [DW-1:0] merged;
    logic          rd_v_q;
    logic [DW-1:0] rd_d_q;
    logic          out_v;
    logic [DW-1:0] out_d;

    nbs_sleep_gate #(.DLY(WAKE_DLY)) u_sleep (
        .clk      (clk),
        .rst      (rst),
        .sleep_i  (sleep),
        .asleep_o (asleep)
    );

    assign go = !cke_n && !asleep;

    nbs_burst_gen #(.AW(AW)) u_burst (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .adv        (adv),
        .cs_n       (cs_n),
        .we_n       (we_n),
        .addr       (addr),
        .interleave (burst_ilv),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr)
    );

    assign cmd_slot.op   = cmd_op;
    assign cmd_slot.addr = cmd_addr;
    assign s1_op         = s1_q.op;

    // The write in stage two takes its data on this edge.
    assign wr_commit = go && (s2_q.op == OP_WRITE);
    assign same_addr = (s1_q.addr == s2_q.addr);

    nbs_array #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_array (
        .clk     (clk),
        .wr_en   (wr_commit),
        .wr_addr (s2_q.addr),
        .wr_be_n (be_n),
        .wr_data (wdata),
        .rd_addr (s1_q.addr),
        .rd_data (arr_rd)
    );

    // Forward in-flight write bytes to a read of the same word.
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_byp
            assign merged[l*LANE_W +: LANE_W] =
                (wr_commit && same_addr && !be_n[l]) ? wdata[l*LANE_W +: LANE_W]
                                                     : arr_rd[l*LANE_W +: LANE_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= '{op: OP_IDLE, addr: '0};
            s2_q   <= '{op: OP_IDLE, addr: '0};
            rd_v_q <= 1'b0;
            rd_d_q <= '0;
            out_v  <= 1'b0;
            out_d  <= '0;
        end else if (go) begin
            s1_q   <= cmd_slot;
            s2_q   <= s1_q;
            rd_v_q <= (s1_q.op == OP_READ);
            if (s1_q.op == OP_READ) rd_d_q <= merged;
            out_v  <= rd_v_q;
            out_d  <= rd_d_q;
        end
    end

    assign rvalid = out_v && !oe_n && !asleep;
    assign rdata  = rvalid ? out_d : '0;
endmodule

// File: rtl/nbs_checker.sv
`timescale 1ns/1ps
module nbs_checker
    import nbs_pkg::*;
#(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst,
    input logic          cke_n,
    input logic          adv,
    input logic [1:0]    cs_n,
    input logic          we_n,
    input logic          sleep,
    input logic          rvalid,
    input logic          go,
    input op_e           s1_op,
    input logic          out_v,
    input logic [DW-1:0] out_d
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)              age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && go && $past(go) &&
         $past(go && !adv && cs_n != 2'b11 && we_n, 2)) |=> out_v);

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
        cke_n |=> ($stable(out_v) && $stable(out_d)));

    assert_deselect_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (go && !adv && cs_n == 2'b11) |=> (s1_op == OP_IDLE));

    assert_continue_deselect_R7: assert property (@(posedge clk) disable iff (rst)
        (go && adv && s1_op == OP_IDLE) |=> (s1_op == OP_IDLE));

    assert_sleep_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && $past(sleep, 2)) |-> !rvalid);
endmodule

bind pipe_burst_sram nbs_checker #(.DW(DW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cke_n  (cke_n),
    .adv    (adv),
    .cs_n   (cs_n),
    .we_n   (we_n),
    .sleep  (sleep),
    .rvalid (rvalid),
    .go     (go),
    .s1_op  (s1_op),
    .out_v  (out_v),
    .out_d  (out_d)
);

// File: tb/pipe_burst_sram_tb.sv
`timescale 1ns/1ps
module pipe_burst_sram_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        cke_n;
    logic [1:0]  cs_n;
    logic        adv;
    logic        we_n;
    logic [9:0]  addr;
    logic [3:0]  be_n;
    logic [35:0] wdata;
    logic        oe_n;
    logic        burst_ilv;
    logic        sleep;
    logic [35:0] rdata;
    logic        rvalid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    pipe_burst_sram u_dut (
        .clk       (clk),
        .rst       (rst),
        .cke_n     (cke_n),
        .cs_n      (cs_n),
        .adv       (adv),
        .we_n      (we_n),
        .addr      (addr),
        .be_n      (be_n),
        .wdata     (wdata),
        .oe_n      (oe_n),
        .burst_ilv (burst_ilv),
        .sleep     (sleep),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );

    localparam logic [35:0] D0 = 36'h123456789;
    localparam logic [35:0] D1 = 36'h0AAAA5555;
    localparam logic [35:0] D2 = 36'hF0F0F0F0F;
    localparam logic [35:0] D3 = 36'h111111111;
    localparam logic [35:0] ONES = 36'hFFFFFFFFF;
    localparam logic [35:0] MRG  = 36'h117FD11FF;

    typedef struct packed {
        logic        cke_n;
        logic [1:0]  cs_n;
        logic        adv;
        logic        we_n;
        logic [9:0]  addr;
        logic [35:0] wd;
        logic [3:0]  be_n;
        logic        ev;
        logic [35:0] ed;
    } vec_t;

    // One row per edge; expected output is sampled after that edge.
    localparam vec_t VEC [13] = '{
        '{1'b0, 2'b10, 1'b0, 1'b0, 10'h010, 36'h0, 4'hF,    1'b0, 36'h0},
        '{1'b0, 2'b10, 1'b0, 1'b0, 10'h011, 36'h0, 4'hF,    1'b0, 36'h0},
        '{1'b0, 2'b10, 1'b0, 1'b1, 10'h010, D0,    4'h0,    1'b0, 36'h0},
        '{1'b0, 2'b10, 1'b0, 1'b0, 10'h012, D1,    4'h0,    1'b0, 36'h0},
        '{1'b0, 2'b01, 1'b0, 1'b1, 10'h012, 36'h0, 4'hF,    1'b1, D0},
        '{1'b0, 2'b11, 1'b0, 1'b1, 10'h000, D2,    4'h0,    1'b0, 36'h0},
        '{1'b0, 2'b11, 1'b0, 1'b1, 10'h000, 36'h0, 4'hF,    1'b1, D2},
        '{1'b0, 2'b10, 1'b0, 1'b0, 10'h013, 36'h0, 4'hF,    1'b0, 36'h0},
        '{1'b0, 2'b10, 1'b0, 1'b0, 10'h013, 36'h0, 4'hF,    1'b0, 36'h0},
        '{1'b0, 2'b11, 1'b0, 1'b1, 10'h000, D3,    4'h0,    1'b0, 36'h0},
        '{1'b0, 2'b10, 1'b0, 1'b1, 10'h013, ONES,  4'b1010, 1'b0, 36'h0},
        '{1'b0, 2'b11, 1'b0, 1'b1, 10'h000, 36'h0, 4'hF,    1'b0, 36'h0},
        '{1'b0, 2'b11, 1'b0, 1'b1, 10'h000, 36'h0, 4'hF,    1'b1, MRG}
    };

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic check(input string tag, input logic ev, input logic [35:0] ed);
        n_checks++;
        if (rvalid !== ev || (ev && rdata !== ed)) begin
            n_fail++;
            $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     tag, rvalid, rdata, ev, ed);
        end
    endtask

    task automatic cyc(input logic [1:0] cs, input logic a, input logic we,
                       input logic [9:0] ad, input logic [35:0] wd, input logic [3:0] be);
        cke_n = 1'b0; cs_n = cs; adv = a; we_n = we; addr = ad; wdata = wd; be_n = be;
        tick();
    endtask

    task automatic nop();
        cyc(2'b11, 1'b0, 1'b1, 10'h000, 36'h0, 4'hF);
    endtask

    localparam logic [35:0] E0 = 36'h000001000;
    localparam logic [35:0] E1 = 36'h000002001;
    localparam logic [35:0] E2 = 36'h000003002;
    localparam logic [35:0] E3 = 36'h000004003;

    initial begin
        rst = 1'b1; cke_n = 1'b0; cs_n = 2'b11; adv = 1'b0; we_n = 1'b1;
        addr = '0; be_n = 4'hF; wdata = '0; oe_n = 1'b0; burst_ilv = 1'b0; sleep = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        check("R10 reset state", 1'b0, 36'h0);

        // Table walk: R1 R3 R6 R9 with back-to-back read/write and R7 deselects
        for (int i = 0; i < 13; i++) begin
            cke_n = VEC[i].cke_n; cs_n = VEC[i].cs_n; adv = VEC[i].adv;
            we_n = VEC[i].we_n; addr = VEC[i].addr; wdata = VEC[i].wd; be_n = VEC[i].be_n;
            tick();
            check($sformatf("R1/R3/R6/R9 table row %0d", i), VEC[i].ev, VEC[i].ed);
        end

        // R4: linear write burst from low bits 01, interleaved read burst back
        burst_ilv = 1'b0;
        cyc(2'b10, 1'b0, 1'b0, 10'h021, 36'h0, 4'hF);
        cyc(2'b11, 1'b1, 1'b1, 10'h000, 36'h0, 4'hF);
        cyc(2'b11, 1'b1, 1'b1, 10'h000, E0, 4'h0);
        cyc(2'b11, 1'b1, 1'b1, 10'h000, E1, 4'h0);
        burst_ilv = 1'b1;
        cyc(2'b10, 1'b0, 1'b1, 10'h021, E2, 4'h0);
        cyc(2'b10, 1'b1, 1'b0, 10'h000, E3, 4'h0);
        cyc(2'b10, 1'b1, 1'b0, 10'h000, 36'h0, 4'hF);
        check("R4 interleaved beat0 addr 021", 1'b1, E0);
        cyc(2'b10, 1'b1, 1'b0, 10'h000, 36'h0, 4'hF);
        check("R4 interleaved beat1 addr 020", 1'b1, E3);
        cyc(2'b10, 1'b1, 1'b0, 10'h000, 36'h0, 4'hF);
        check("R4 interleaved beat2 addr 023", 1'b1, E2);
        nop();
        check("R4 interleaved beat3 addr 022", 1'b1, E1);
        nop();
        check("R4 fifth beat wraps to 021", 1'b1, E0);
        burst_ilv = 1'b0;

        // R5: stall freezes pipeline and ignores a command presented meanwhile
        cyc(2'b10, 1'b0, 1'b1, 10'h010, 36'h0, 4'hF);
        cke_n = 1'b1; cs_n = 2'b10; adv = 1'b0; we_n = 1'b0; addr = 10'h010; wdata = '0; be_n = 4'h0;
        tick();
        tick();
        check("R5 stalled edges give no data", 1'b0, 36'h0);
        cyc(2'b11, 1'b0, 1'b1, 10'h000, 36'h0, 4'h0);
        check("R5 one enabled edge only", 1'b0, 36'h0);
        nop();
        check("R5 read after two enabled edges", 1'b1, D0);
        cke_n = 1'b1;
        tick();
        check("R5 output held while stalled", 1'b1, D0);
        oe_n = 1'b1; #1;
        check("R2 oe_n high drops rvalid", 1'b0, 36'h0);
        oe_n = 1'b0; #1;
        check("R2 oe_n low restores data", 1'b1, D0);

        // R6: write with all byte enables high is a no-op
        cyc(2'b10, 1'b0, 1'b0, 10'h010, 36'h0, 4'hF);
        nop();
        cyc(2'b10, 1'b0, 1'b1, 10'h010, 36'h0, 4'hF);
        nop();
        nop();
        check("R6 aborted write left D0", 1'b1, D0);

        // R7: continue-deselect after a deselect performs no access
        nop();
        cyc(2'b10, 1'b1, 1'b1, 10'h010, 36'h0, 4'hF);
        cyc(2'b10, 1'b1, 1'b1, 10'h010, 36'h0, 4'hF);
        nop();
        check("R7 continue deselect no data", 1'b0, 36'h0);
        nop();
        check("R7 continue deselect no data later", 1'b0, 36'h0);

        // R8: sleep entry, ignored write, wake with state preserved
        nop();
        nop();
        cyc(2'b10, 1'b0, 1'b1, 10'h010, 36'h0, 4'hF);
        sleep = 1'b1;
        nop();
        nop();
        check("R8 rvalid low while asleep", 1'b0, 36'h0);
        cyc(2'b10, 1'b0, 1'b0, 10'h010, 36'h0, 4'hF);
        cyc(2'b10, 1'b1, 1'b0, 10'h000, 36'h0, 4'hF);
        check("R8 still asleep", 1'b0, 36'h0);
        sleep = 1'b0;
        cyc(2'b11, 1'b0, 1'b1, 10'h000, 36'h0, 4'h0);
        cyc(2'b11, 1'b0, 1'b1, 10'h000, 36'h0, 4'h0);
        check("R8 pending result kept across sleep", 1'b1, D0);
        cyc(2'b10, 1'b0, 1'b1, 10'h010, 36'h0, 4'hF);
        nop();
        nop();
        check("R8 write during sleep ignored", 1'b1, D0);

        // R10: reset mid-run clears output and burst state
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check("R10 reset drops rvalid", 1'b0, 36'h0);
        cyc(2'b10, 1'b1, 1'b1, 10'h010, 36'h0, 4'hF);
        nop();
        check("R10 adv after reset no access", 1'b0, 36'h0);
        nop();
        check("R10 adv after reset still no data", 1'b0, 36'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule